// File: doc/BRIEF.md
# Byte/Word Memory Bus Router

This block sits between a 16-bit processor's address/data bus and the memories and peripherals of a flat 64 KB address space. For each request it picks exactly one target region, steers the little-endian byte lanes for byte and word transfers, and applies each region's rules on access width and write protection. Regions answer on a shared request bus with one-hot selects. Their read data is taken in the request cycle, shaped to the access width, and returned to the processor one clock later, together with error and vector flags.

Six regions are decoded:
- a byte-wide special-function window
- a byte-wide peripheral window
- a word-wide peripheral window
- RAM of parameterised size
- a read-only boot window
- flash, from a parameterised base up to the top of memory

Reads from the top 32 bytes are flagged as interrupt-vector fetches and carry a priority index.

Top module: `membus_router`

## Requirements
- R1: Region map and select index: 0x0000–0x000F special-function (sel[0]), 0x0010–0x00FF byte peripherals (sel[1]), 0x0100–0x01FF word peripherals (sel[2]), 0x0200 to 0x0200+RAM_BYTES-1 RAM (sel[3]), 0x0C00–0x0FFF boot (sel[4]), FLASH_BASE–0xFFFF flash (sel[5]). At most one select is high, and only while `cpu_req` is high and the access is accepted.
- R2: A word access drives `reg_ben`=2'b11, passes `cpu_wdata` unchanged, and puts an even address on `reg_addr`; byte 0 of a word is the low lane [7:0].
- R3: A byte write to an even address drives `reg_ben`=2'b01, and to an odd address 2'b10. The byte from `cpu_wdata[7:0]` is copied onto both lanes of `reg_wdata`.
- R4: A word access to an odd address is sent to the even address below it, and `err_misalign` is high for exactly the following cycle.
- R5: Every read sets `cpu_rvalid` one clock after the request, with `cpu_rdata` valid in that same cycle. A byte read returns the addressed lane in [7:0] with [15:8] cleared; an odd address takes the region's [15:8].
- R6: A word access to either byte-wide window drives `reg_ben`=2'b01 with `cpu_wdata[7:0]` in the low lane and zero in the high lane; a word read returns the region's low byte zero-extended.
- R7: A byte access to the word peripheral window selects no region. It sets `err_width` in the next cycle, and a read returns 0x0000.
- R8: A write to the boot window selects no region and sets `err_wprot` in the next cycle. Reads from the boot window are served normally.
- R9: An address outside every region selects nothing. It sets `err_unmapped` in the next cycle, and a read returns 0x0000.
- R10: A read at 0xFFE0–0xFFFF sets `vec_hit` in the next cycle with `vec_idx` = (address − 0xFFE0)/2, so 15 is the highest priority. Writes there and reads elsewhere leave `vec_hit` low and `vec_idx` zero.
- R11: While and right after `rst`, all registered outputs are zero.
- R12: The flash window moves with FLASH_BASE: the address just below the base is unmapped, and the base itself selects flash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_byte | input | 1 | 1 = byte transfer, 0 = word transfer |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write data (byte writes use [7:0]) |
| cpu_rdata | output | 16 | Read data, one cycle after request |
| cpu_rvalid | output | 1 | Read data valid |
| err_unmapped | output | 1 | Previous access hit no region |
| err_misalign | output | 1 | Previous word access had an odd address |
| err_width | output | 1 | Previous access was a byte access to the word peripherals |
| err_wprot | output | 1 | Previous access was a write to boot memory |
| vec_hit | output | 1 | Previous read was in the vector table |
| vec_idx | output | 4 | Vector priority index of that read |
| reg_sel | output | 6 | One-hot region select |
| reg_we | output | 1 | Write strobe to the selected region |
| reg_addr | output | 16 | Aligned address to regions |
| reg_ben | output | 2 | Byte-lane enables (bit 0 = low lane) |
| reg_wdata | output | 16 | Lane-steered write data |
| reg_rdata | input | 96 | Region read data, region i at [16*i+15:16*i] |

## Verification
A wrong region classification shows in the same cycle as a wrong or missing bit on `reg_sel`, and one clock later as an unexpected error flag or the wrong region's data on `cpu_rdata`. A lane-steering fault appears at once on `reg_ben`/`reg_wdata` for writes, or one clock later as the wrong byte or an unzeroed upper byte on reads. Each registered flag is compared against a behavioural model on every clock, so a stuck or stretched flag is caught in the cycle after it goes wrong.

// File: rtl/membus_pkg.sv
package membus_pkg;

    localparam int NREG  = 6;
    localparam int DW    = 16;
    localparam int VIDXW = 4;

    typedef enum logic [2:0] {
        RG_SFR   = 3'd0,
        RG_PER8  = 3'd1,
        RG_PER16 = 3'd2,
        RG_RAM   = 3'd3,
        RG_BOOT  = 3'd4,
        RG_FLASH = 3'd5,
        RG_NONE  = 3'd6
    } region_e;

    typedef struct packed {
        logic    grant;
        logic    narrow;
        logic    lane_hi;
        logic    byte_acc;
        region_e rg;
    } route_t;

    typedef struct packed {
        logic             rvalid;
        logic             e_unmap;
        logic             e_mis;
        logic             e_width;
        logic             e_wprot;
        logic             vec;
        logic [VIDXW-1:0] vidx;
    } flags_t;

    function automatic region_e classify(input logic [15:0] a,
                                         input logic [15:0] ram_last,
                                         input logic [15:0] flash_base);
        if (a <= 16'h000F)                    return RG_SFR;
        if (a <= 16'h00FF)                    return RG_PER8;
        if (a <= 16'h01FF)                    return RG_PER16;
        if (a <= ram_last)                    return RG_RAM;
        if (a >= 16'h0C00 && a <= 16'h0FFF)   return RG_BOOT;
        if (a >= flash_base)                  return RG_FLASH;
        return RG_NONE;
    endfunction

    function automatic logic is_narrow(input region_e r);
        return (r == RG_SFR) || (r == RG_PER8);
    endfunction

endpackage

// File: rtl/membus_decode.sv
module membus_decode
    import membus_pkg::*;
#(
    parameter int          RAM_BYTES  = 512,
    parameter logic [15:0] FLASH_BASE = 16'hC000
) (
    input  logic            req,
    input  logic            we,
    input  logic            byte_acc,
    input  logic [15:0]     addr,
    output route_t          route,
    output flags_t          flags,
    output logic [15:0]     addr_al,
    output logic [NREG-1:0] sel
);
    localparam logic [15:0] RAM_LAST = 16'(32'h0200 + RAM_BYTES - 1);

    region_e rg;
    logic    rej_width, rej_prot;

    always_comb begin
        rg        = classify(addr, RAM_LAST, FLASH_BASE);
        rej_width = (rg == RG_PER16) && byte_acc;
        rej_prot  = (rg == RG_BOOT) && we;

        route.rg       = rg;
        route.byte_acc = byte_acc;
        route.lane_hi  = byte_acc && addr[0];
        route.narrow   = is_narrow(rg) && !byte_acc;
        route.grant    = req && (rg != RG_NONE) && !rej_width && !rej_prot;

        addr_al = byte_acc ? addr : {addr[15:1], 1'b0};

        flags.rvalid  = req && !we;
        flags.e_unmap = req && (rg == RG_NONE);
        flags.e_mis   = req && !byte_acc && addr[0];
        flags.e_width = req && rej_width;
        flags.e_wprot = req && rej_prot;
        flags.vec     = req && !we && (addr[15:5] == 11'h7FF);
        flags.vidx    = flags.vec ? addr[4:1] : '0;
    end

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        assign sel[i] = route.grant && (rg == region_e'(i));
    end

endmodule

// File: rtl/membus_lanes.sv
module membus_lanes
    import membus_pkg::*;
(
    input  route_t        route,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] raw,
    output logic [1:0]    ben,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] rd_o
);
    always_comb begin
        if (!route.grant) begin
            ben     = 2'b00;
            wdata_o = wdata;
            rd_o    = '0;
        end else if (route.byte_acc) begin
            ben     = route.lane_hi ? 2'b10 : 2'b01;
            wdata_o = {wdata[7:0], wdata[7:0]};
            rd_o    = {8'h00, route.lane_hi ? raw[15:8] : raw[7:0]};
        end else if (route.narrow) begin
            ben     = 2'b01;
            wdata_o = {8'h00, wdata[7:0]};
            rd_o    = {8'h00, raw[7:0]};
        end else begin
            ben     = 2'b11;
            wdata_o = wdata;
            rd_o    = raw;
        end
    end
endmodule

// File: rtl/membus_router.sv
module membus_router
    import membus_pkg::*;
#(
    parameter int          RAM_BYTES  = 512,
    parameter logic [15:0] FLASH_BASE = 16'hC000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic                 cpu_byte,
    input  logic [15:0]          cpu_addr,
    input  logic [15:0]          cpu_wdata,
    output logic [15:0]          cpu_rdata,
    output logic                 cpu_rvalid,
    output logic                 err_unmapped,
    output logic                 err_misalign,
    output logic                 err_width,
    output logic                 err_wprot,
    output logic                 vec_hit,
    output logic [3:0]           vec_idx,
    output logic [NREG-1:0]      reg_sel,
    output logic                 reg_we,
    output logic [15:0]          reg_addr,
    output logic [1:0]           reg_ben,
    output logic [15:0]          reg_wdata,
    input  logic [NREG*DW-1:0]   reg_rdata
);
    route_t        route;
    flags_t        flags, flags_q;
    logic [DW-1:0] raw, shaped, rdata_q;

    membus_decode #(.RAM_BYTES(RAM_BYTES), .FLASH_BASE(FLASH_BASE)) u_dec (
        .req      (cpu_req),
        .we       (cpu_we),
        .byte_acc (cpu_byte),
        .addr     (cpu_addr),
        .route    (route),
        .flags    (flags),
        .addr_al  (reg_addr),
        .sel      (reg_sel)
    );

    always_comb begin
        raw = '0;
        for (int i = 0; i < NREG; i++)
            if (reg_sel[i]) raw = raw | reg_rdata[i*DW +: DW];
    end

    membus_lanes u_lanes (
        .route   (route),
        .wdata   (cpu_wdata),
        .raw     (raw),
        .ben     (reg_ben),
        .wdata_o (reg_wdata),
        .rd_o    (shaped)
    );

    assign reg_we = cpu_we && route.grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            rdata_q <= '0;
        end else begin
            flags_q <= flags;
            rdata_q <= flags.rvalid ? shaped : '0;
        end
    end

    assign cpu_rdata    = rdata_q;
    assign cpu_rvalid   = flags_q.rvalid;
    assign err_unmapped = flags_q.e_unmap;
    assign err_misalign = flags_q.e_mis;
    assign err_width    = flags_q.e_width;
    assign err_wprot    = flags_q.e_wprot;
    assign vec_hit      = flags_q.vec;
    assign vec_idx      = flags_q.vidx;

endmodule

// File: rtl/membus_router_chk.sv
module membus_router_chk
    import membus_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cpu_req,
    input logic            cpu_we,
    input logic            cpu_byte,
    input logic [15:0]     cpu_addr,
    input logic            cpu_rvalid,
    input logic            err_misalign,
    input logic            err_width,
    input logic            err_wprot,
    input logic            vec_hit,
    input logic [NREG-1:0] reg_sel,
    input logic            reg_we,
    input logic [15:0]     reg_addr
);
    // R1: never more than one region selected
    a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_sel));

    // R1: no select without a request
    a_r1_sel_needs_req: assert property (@(posedge clk) disable iff (rst)
        !cpu_req |-> (reg_sel == '0));

    // R2: selected word accesses carry an even address
    a_r2_word_even: assert property (@(posedge clk) disable iff (rst)
        ((|reg_sel) && !cpu_byte) |-> !reg_addr[0]);

    // R4: odd word access flags misalignment next cycle
    a_r4_misalign_flag: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_byte && cpu_addr[0]) |=> err_misalign);

    // R5: read data valid one cycle after a read request
    a_r5_rvalid_next: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_we) |=> cpu_rvalid);

    // R7: byte access to word peripherals rejected and flagged
    a_r7_width_reject: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_byte && cpu_addr[15:8] == 8'h01) |-> (reg_sel == '0));
    a_r7_width_flag: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_byte && cpu_addr[15:8] == 8'h01) |=> err_width);

    // R8: boot window never receives a write
    a_r8_boot_nowrite: assert property (@(posedge clk) disable iff (rst)
        reg_sel[4] |-> !reg_we);
    a_r8_wprot_flag: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_addr[15:10] == 6'b000011) |=> err_wprot);

    // R10: vector flag only accompanies read data
    a_r10_vec_is_read: assert property (@(posedge clk) disable iff (rst)
        vec_hit |-> cpu_rvalid);

endmodule

bind membus_router membus_router_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_byte     (cpu_byte),
    .cpu_addr     (cpu_addr),
    .cpu_rvalid   (cpu_rvalid),
    .err_misalign (err_misalign),
    .err_width    (err_width),
    .err_wprot    (err_wprot),
    .vec_hit      (vec_hit),
    .reg_sel      (reg_sel),
    .reg_we       (reg_we),
    .reg_addr     (reg_addr)
);

// File: tb/tb_membus_router.sv
`timescale 1ns/1ps
module tb_membus_router;
    localparam int          RAMB  = 512;
    localparam logic [15:0] FBASE = 16'hC000;
    localparam int          NR    = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 0, cpu_we = 0, cpu_byte = 0;
    logic [15:0] cpu_addr = 0, cpu_wdata = 0;
    logic [15:0] cpu_rdata;
    logic        cpu_rvalid, err_unmapped, err_misalign, err_width, err_wprot, vec_hit;
    logic [3:0]  vec_idx;
    logic [NR-1:0] reg_sel;
    logic        reg_we;
    logic [15:0] reg_addr, reg_wdata;
    logic [1:0]  reg_ben;
    logic [NR*16-1:0] reg_rdata;

    always #2 clk = ~clk;  // 250 MHz

    membus_router #(.RAM_BYTES(RAMB), .FLASH_BASE(FBASE)) dut (.*);

    // region responders: word value depends on region and address
    for (genvar i = 0; i < NR; i++) begin : g_resp
        assign reg_rdata[i*16 +: 16] = reg_addr ^ (16'h1111 * 16'(i + 1));
    end

    int checks = 0, fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // expected registered outputs, one entry per driven cycle
    typedef struct packed {
        logic [15:0] rdata; logic rvalid, unm, mis, wid, wpr, vec; logic [3:0] vidx;
    } exp_t;
    exp_t pend[$];

    function automatic int region_of(input logic [15:0] a);
        if (a < 16'h0010) return 0;
        if (a < 16'h0100) return 1;
        if (a < 16'h0200) return 2;
        if (int'(a) < 16'h0200 + RAMB) return 3;
        if (a >= 16'h0C00 && a < 16'h1000) return 4;
        if (a >= FBASE) return 5;
        return -1;
    endfunction

    task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // compare registered outputs produced by the previous cycle's request
    task automatic check_regd();
        exp_t e, a;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        a = {cpu_rdata, cpu_rvalid, err_unmapped, err_misalign, err_width, err_wprot, vec_hit, vec_idx};
        check("R5/R4/R7/R8/R9/R10 registered outputs", a == e, 64'(a), 64'(e));
    endtask

    task automatic access(input logic we, input logic byt, input logic [15:0] a, input logic [15:0] wd,
                          input string tag);
        int rg; logic grant, narrow; logic [15:0] al, raw, shp, ewd; logic [1:0] eben; exp_t e;
        @(negedge clk);
        check_regd();
        cpu_req = 1; cpu_we = we; cpu_byte = byt; cpu_addr = a; cpu_wdata = wd;
        rg     = region_of(a);
        narrow = (rg == 0 || rg == 1) && !byt;
        grant  = (rg >= 0) && !(rg == 2 && byt) && !(rg == 4 && we);
        al     = byt ? a : (a & 16'hFFFE);
        raw    = (rg >= 0) ? (al ^ (16'h1111 * 16'(rg + 1))) : 16'h0;
        if (byt) begin eben = a[0] ? 2'b10 : 2'b01; ewd = {wd[7:0], wd[7:0]}; shp = {8'h0, a[0] ? raw[15:8] : raw[7:0]}; end
        else if (narrow) begin eben = 2'b01; ewd = {8'h0, wd[7:0]}; shp = {8'h0, raw[7:0]}; end
        else begin eben = 2'b11; ewd = wd; shp = raw; end
        #1;
        check({tag, " R1 select"}, reg_sel == (grant ? NR'(1 << rg) : NR'(0)), 64'(reg_sel),
              64'(grant ? (1 << rg) : 0));
        if (grant) begin
            check({tag, " R2/R3/R6 addr+ben"}, {reg_addr, reg_ben, reg_we} == {al, eben, we},
                  64'({reg_addr, reg_ben, reg_we}), 64'({al, eben, we}));
            if (we) check({tag, " R3/R6 wdata"}, reg_wdata == ewd, 64'(reg_wdata), 64'(ewd));
        end else
            check({tag, " R7/R8/R9 no write strobe"}, reg_we == 1'b0, 64'(reg_we), 64'(0));
        e.rvalid = !we;
        e.rdata  = (!we && grant) ? shp : 16'h0;
        e.unm    = (rg < 0);
        e.mis    = !byt && a[0];
        e.wid    = (rg == 2) && byt;
        e.wpr    = (rg == 4) && we;
        e.vec    = !we && (a >= 16'hFFE0);
        e.vidx   = e.vec ? 4'((int'(a) - 16'hFFE0) / 2) : 4'h0;
        pend.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        check_regd();
        cpu_req = 0; cpu_we = 0; cpu_byte = 0;
        pend.push_back('0);
        #1 check("R1 idle select", reg_sel == '0, 64'(reg_sel), 64'(0));
    endtask

    initial begin : watchdog
        #400000;
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset outputs", {cpu_rdata, cpu_rvalid, err_unmapped, err_misalign, err_width,
              err_wprot, vec_hit, vec_idx} == '0, 64'(cpu_rdata), 64'(0));
        rst = 0;
        idle();
        // R1 each region, word and byte reads
        access(0, 1, 16'h0005, 0, "R1 sfr byte");
        access(0, 0, 16'h0040, 0, "R6 per8 word read");
        access(0, 0, 16'h0120, 0, "R1 per16 word");
        access(0, 0, 16'h0300, 0, "R1 ram word");
        access(0, 1, 16'h0301, 0, "R5 ram odd byte read");
        access(0, 1, 16'h0302, 0, "R5 ram even byte read");
        access(0, 0, 16'h0C10, 0, "R8 boot read");
        access(0, 0, 16'hC000, 0, "R12 flash base");
        // writes and lanes
        access(1, 0, 16'h0210, 16'hBEEF, "R2 ram word write");
        access(1, 1, 16'h0210, 16'h00A5, "R3 ram even byte write");
        access(1, 1, 16'h0211, 16'h005A, "R3 ram odd byte write");
        access(1, 0, 16'h0020, 16'h1234, "R6 per8 word write");
        // misalign
        access(0, 0, 16'h0305, 0, "R4 odd word read");
        access(1, 0, 16'h0131, 16'h4321, "R4 odd word write per16");
        // width rule
        access(0, 1, 16'h0150, 0, "R7 per16 byte read");
        access(1, 1, 16'h0151, 16'h0077, "R7 per16 byte write");
        // boot protect
        access(1, 0, 16'h0E00, 16'hDEAD, "R8 boot write");
        // unmapped
        access(0, 0, 16'h0400, 0, "R9 past ram end");
        access(0, 0, 16'h3000, 0, "R9 gap");
        access(0, 0, 16'hBFFE, 0, "R12 below flash base");
        access(0, 0, 16'h03FE, 0, "R1 ram last word");
        // vectors
        access(0, 0, 16'hFFE0, 0, "R10 vector 0");
        access(0, 0, 16'hFFFE, 0, "R10 vector 15");
        access(0, 1, 16'hFFF1, 0, "R10 vector byte");
        access(1, 0, 16'hFFF0, 16'h1111, "R10 vector write");
        access(0, 0, 16'hFFDE, 0, "R10 below table");
        idle();
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            logic [15:0] a;
            a = 16'($urandom);
            case (k % 5)
                0: a = {8'h00, a[7:0]};
                1: a = {7'h01, a[8:0]};
                2: a = {6'b000011, a[9:0]};
                default: ;
            endcase
            if (k % 7 == 0) idle();
            else access(1'($urandom), 1'($urandom), a, 16'($urandom), "mixed");
        end
        idle();
        idle();
        @(negedge clk);
        check_regd();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule